// File: doc/BRIEF.md
# Three-Level H-Bridge PWM Modulator

This block turns a signed digital drive sample into the switch commands for the two legs of a full H-bridge. It uses three-level (BD) modulation. Both legs run on a shared counter carrier. Each leg is high for a number of clocks set by the sample: the positive leg stays high longer for a positive sample, and the negative leg stays high longer for a negative sample. With a zero sample the two legs switch identically and in phase, so the load sees almost no differential voltage. Each leg output is a single logic command. A value of 1 means the leg is tied to the supply rail, and 0 means it is tied to ground. A separate per-leg enable lets the power stage float the leg.

The carrier period is `PER_SLOW` clocks (400 kHz at 100 MHz) or `PER_FAST` clocks (500 kHz), chosen by a select bit. The sample and the select bit are read only at a period boundary. A high-impedance request turns both legs and both enables off and holds them off while the request stays high.

The control state machine has three states:
- `ST_OFF`: bridge idle, everything low.
- `ST_START`: a one-cycle state that loads the sample and frequency and clears the carrier.
- `ST_RUN`: modulating.

The transitions are:
- OFF→START when no request is pending.
- START→RUN unconditionally unless a request is pending.
- RUN→RUN, which reloads at every wrap.
- Any state→OFF whenever the high-impedance request is sampled high.

Top module: `bd_bridge_modulator`

## Requirements
- R1: After reset both leg commands and both leg enables are 0.
- R2: With a sample of 0, both legs are high for exactly half the period and are equal on every clock.
- R3: For a sample s (two's complement, `SAMPLE_W` bits, full scale F = 2^(SAMPLE_W-1)) with period P, let half = P/2 and delta = floor(s·half/F). Each period, the positive leg is high for half+delta clocks and the negative leg is high for half−delta clocks, before the clamp of R5 is applied.
- R4: A negative sample gives the mirrored result: the negative leg's high time exceeds half and the positive leg's is below it, following the same formula.
- R5: Each leg's high count is clamped to the range [P − M, M], where M = floor(P·96/100) − 1. This gives 239/11 at P=250 and 191/9 at P=200.
- R6: `freq_sel_i`=0 gives a carrier period of 250 clocks and `freq_sel_i`=1 gives 200 clocks.
- R7: A change of the sample or the select bit during a period does not alter that period; it takes effect from the next period boundary.
- R8: When `hiz_i` is sampled high on a clock edge, all four outputs are 0 after that edge, and they stay 0 while the request remains high.
- R9: After `hiz_i` returns low, the enables rise on the third clock edge. On that edge both legs go high together at the start of a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Signed drive sample |
| freq_sel_i | input | 1 | Carrier select: 0 slow period, 1 fast period |
| hiz_i | input | 1 | High-impedance request |
| leg_p_o | output | 1 | Positive leg command (1 = rail, 0 = ground) |
| leg_n_o | output | 1 | Negative leg command (1 = rail, 0 = ground) |
| en_p_o | output | 1 | Positive leg enable |
| en_n_o | output | 1 | Negative leg enable |

## Verification
A high-impedance request and a period wrap can fall on the same clock edge. On that edge the carrier wants to reload a new sample at the moment the bridge must shut off. The bench waits in its own reference model until the carrier sits on the last count of a period. It then raises the request and changes the sample in that same cycle. It checks that all outputs are low after the edge, and that the restart after release uses the new sample. Mid-period sample changes are judged the same way, by checking that the legs stay identical until the boundary.

// File: rtl/bd_mod_pkg.sv
package bd_mod_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_START = 2'd1,
        ST_RUN   = 2'd2
    } bd_state_e;

    localparam int NUM_LEGS = 2;
    localparam int LEG_POS  = 0;
    localparam int LEG_NEG  = 1;

endpackage

// File: rtl/bd_duty_calc.sv
module bd_duty_calc #(
    parameter int SAMPLE_W     = 12,
    parameter int CNT_W        = 8,
    parameter int PER_SLOW     = 250,
    parameter int PER_FAST     = 200,
    parameter int DUTY_MAX_PCT = 96
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       freq_sel_i,
    output logic [CNT_W-1:0]           per_o,
    output logic [CNT_W-1:0]           hi_p_o,
    output logic [CNT_W-1:0]           hi_n_o
);

    localparam int HMAX_S = (PER_SLOW * DUTY_MAX_PCT) / 100 - 1;
    localparam int HMIN_S = PER_SLOW - HMAX_S;
    localparam int HMAX_F = (PER_FAST * DUTY_MAX_PCT) / 100 - 1;
    localparam int HMIN_F = PER_FAST - HMAX_F;
    localparam int SHIFT  = SAMPLE_W - 1;

    function automatic int clamp_span(input int v, input int lo, input int hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

    int per_v, half_v, prod_v, delta_v, hmax_v, hmin_v, hp_v, hn_v;

    always_comb begin
        per_v   = freq_sel_i ? PER_FAST : PER_SLOW;
        hmax_v  = freq_sel_i ? HMAX_F : HMAX_S;
        hmin_v  = freq_sel_i ? HMIN_F : HMIN_S;
        half_v  = per_v / 2;
        prod_v  = int'(sample_i) * half_v;
        delta_v = prod_v >>> SHIFT;          // floor division by full scale
        hp_v    = clamp_span(half_v + delta_v, hmin_v, hmax_v);
        hn_v    = clamp_span(half_v - delta_v, hmin_v, hmax_v);
    end

    assign per_o  = CNT_W'(per_v);
    assign hi_p_o = CNT_W'(hp_v);
    assign hi_n_o = CNT_W'(hn_v);

endmodule

// File: rtl/bd_carrier.sv
module bd_carrier #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = run_i && (cnt_q == per_i - CNT_W'(1));
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || wrap_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/bd_leg.sv
module bd_leg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic             drive_o,
    output logic             en_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_o <= 1'b0;
            en_o    <= 1'b0;
        end else begin
            en_o    <= gate_i;
            drive_o <= gate_i && (cnt_i < hi_i);
        end
    end

endmodule

// File: rtl/bd_bridge_modulator.sv
module bd_bridge_modulator
    import bd_mod_pkg::*;
#(
    parameter int SAMPLE_W     = 12,
    parameter int PER_SLOW     = 250,
    parameter int PER_FAST     = 200,
    parameter int DUTY_MAX_PCT = 96
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       freq_sel_i,
    input  logic                       hiz_i,
    output logic                       leg_p_o,
    output logic                       leg_n_o,
    output logic                       en_p_o,
    output logic                       en_n_o
);

    localparam int PER_MAX = (PER_SLOW > PER_FAST) ? PER_SLOW : PER_FAST;
    localparam int CNT_W   = $clog2(PER_MAX + 1);
    localparam int HMAX_S  = (PER_SLOW * DUTY_MAX_PCT) / 100 - 1;
    localparam int HMAX_F  = (PER_FAST * DUTY_MAX_PCT) / 100 - 1;

    bd_state_e state_q, state_d;

    logic [CNT_W-1:0] per_q, hp_q, hn_q;
    logic [CNT_W-1:0] per_d, hp_d, hn_d;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             run, gate, load;
    logic [CNT_W-1:0] hi_sel [NUM_LEGS];
    logic             drive  [NUM_LEGS];
    logic             en     [NUM_LEGS];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = hiz_i ? ST_OFF : ST_START;
            ST_START: state_d = hiz_i ? ST_OFF : ST_RUN;
            ST_RUN:   state_d = hiz_i ? ST_OFF : ST_RUN;
            default:  state_d = ST_OFF;
        endcase
    end

    // state-derived controls
    always_comb begin
        run  = (state_q == ST_RUN);
        gate = run && !hiz_i;
        load = (state_q == ST_START) || wrap;
    end

    bd_duty_calc #(
        .SAMPLE_W    (SAMPLE_W),
        .CNT_W       (CNT_W),
        .PER_SLOW    (PER_SLOW),
        .PER_FAST    (PER_FAST),
        .DUTY_MAX_PCT(DUTY_MAX_PCT)
    ) u_duty (
        .sample_i  (sample_i),
        .freq_sel_i(freq_sel_i),
        .per_o     (per_d),
        .hi_p_o    (hp_d),
        .hi_n_o    (hn_d)
    );

    // period-boundary capture of setpoints
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= CNT_W'(PER_SLOW);
            hp_q  <= CNT_W'(PER_SLOW / 2);
            hn_q  <= CNT_W'(PER_SLOW / 2);
        end else if (load) begin
            per_q <= per_d;
            hp_q  <= hp_d;
            hn_q  <= hn_d;
        end
    end

    bd_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .per_i (per_q),
        .cnt_o (cnt),
        .wrap_o(wrap)
    );

    assign hi_sel[LEG_POS] = hp_q;
    assign hi_sel[LEG_NEG] = hn_q;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        bd_leg #(.CNT_W(CNT_W)) u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .gate_i (gate),
            .cnt_i  (cnt),
            .hi_i   (hi_sel[g]),
            .drive_o(drive[g]),
            .en_o   (en[g])
        );
    end

    assign leg_p_o = drive[LEG_POS];
    assign leg_n_o = drive[LEG_NEG];
    assign en_p_o  = en[LEG_POS];
    assign en_n_o  = en[LEG_NEG];

    // assertion helpers
    logic [CNT_W-1:0] lim_hi, lim_lo;
    assign lim_hi = (per_q == CNT_W'(PER_FAST)) ? CNT_W'(HMAX_F) : CNT_W'(HMAX_S);
    assign lim_lo = per_q - lim_hi;

    AST_HIZ_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_i |=> (!en_p_o && !en_n_o && !leg_p_o && !leg_n_o)); // R8

    AST_LEG_P_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        leg_p_o |-> en_p_o); // R8

    AST_LEG_N_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        leg_n_o |-> en_n_o); // R8

    AST_HOLD_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(hp_q) && $stable(hn_q) && $stable(per_q))); // R7

    AST_DUTY_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (hp_q <= lim_hi && hp_q >= lim_lo && hn_q <= lim_hi && hn_q >= lim_lo)); // R5

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < per_q)); // R6

    AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_p_o) |-> (leg_p_o && leg_n_o)); // R9

endmodule

// File: tb/bd_bridge_modulator_test.sv
module bd_bridge_modulator_test;

    localparam int SAMPLE_W = 12;
    localparam int PER_SLOW = 250;
    localparam int PER_FAST = 200;
    localparam int FULL     = 1 << (SAMPLE_W - 1);

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic signed [SAMPLE_W-1:0] sample = '0;
    logic                       fsel = 1'b0;
    logic                       hiz = 1'b0;
    logic                       leg_p_o, leg_n_o, en_p_o, en_n_o;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    // reference model state
    int m_st = 0, m_cnt = 0, m_per = PER_SLOW, m_hp = PER_SLOW/2, m_hn = PER_SLOW/2;
    bit e_en = 0, e_p = 0, e_n = 0;

    always #5 clk = ~clk;

    bd_bridge_modulator #(.SAMPLE_W(SAMPLE_W), .PER_SLOW(PER_SLOW), .PER_FAST(PER_FAST)) uut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .freq_sel_i(fsel), .hiz_i(hiz),
        .leg_p_o(leg_p_o), .leg_n_o(leg_n_o), .en_p_o(en_p_o), .en_n_o(en_n_o)
    );

    function automatic int ref_hi(input int s, input int per, input bit pos);
        int half, prod, delta, v, mx, mn;
        half  = per / 2;
        prod  = s * half;
        delta = (prod >= 0) ? prod / FULL : -((-prod + FULL - 1) / FULL);
        v     = pos ? half + delta : half - delta;
        mx    = (per * 96) / 100 - 1;
        mn    = per - mx;
        if (v > mx) v = mx;
        if (v < mn) v = mn;
        return v;
    endfunction

    function automatic int per_of(input bit f);
        return f ? PER_FAST : PER_SLOW;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_per = PER_SLOW; m_hp = PER_SLOW/2; m_hn = PER_SLOW/2;
            e_en = 0; e_p = 0; e_n = 0;
        end else begin
            bit wrapped, ld;
            e_en = (m_st == 2) && !hiz;
            e_p  = e_en && (m_cnt < m_hp);
            e_n  = e_en && (m_cnt < m_hn);
            wrapped = (m_st == 2) && (m_cnt == m_per - 1);
            ld = (m_st == 1) || wrapped;
            if (m_st == 2 && !wrapped) m_cnt = m_cnt + 1;
            else m_cnt = 0;
            if (ld) begin
                m_per = per_of(fsel);
                m_hp  = ref_hi(int'(sample), m_per, 1'b1);
                m_hn  = ref_hi(int'(sample), m_per, 1'b0);
            end
            if (hiz) m_st = 0;
            else if (m_st == 0) m_st = 1;
            else m_st = 2;
        end
    end

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check_bit(en_p_o, e_en, "R8 model en_p");
            check_bit(en_n_o, e_en, "R8 model en_n");
            check_bit(leg_p_o, e_p, "R3 R7 model leg_p");
            check_bit(leg_n_o, e_n, "R4 R7 model leg_n");
        end
    end

    task automatic apply(input int s, input bit f);
        @(negedge clk);
        sample = SAMPLE_W'(s);
        fsel = f;
        repeat (2 * PER_SLOW + 4) @(negedge clk);
    endtask

    task automatic measure(input int s, input bit f, input string tag);
        int per, cp, cn, ndiff;
        per = per_of(f);
        cp = 0; cn = 0; ndiff = 0;
        repeat (4 * per) begin
            @(negedge clk);
            cp += int'(leg_p_o);
            cn += int'(leg_n_o);
            if (leg_p_o !== leg_n_o) ndiff++;
        end
        check_int(cp, 4 * ref_hi(s, per, 1'b1), {tag, " leg_p high clocks"});
        check_int(cn, 4 * ref_hi(s, per, 1'b0), {tag, " leg_n high clocks"});
        if (s == 0) check_int(ndiff, 0, "R2 legs differ on some clock");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit(leg_p_o, 1'b0, "R1 leg_p in reset");
        check_bit(leg_n_o, 1'b0, "R1 leg_n in reset");
        check_bit(en_p_o, 1'b0, "R1 en_p in reset");
        check_bit(en_n_o, 1'b0, "R1 en_n in reset");
        rst_n = 1'b1;
        cmp_on = 1'b1;

        apply(0, 1'b0);         measure(0, 1'b0, "R2 zero slow");
        apply(1024, 1'b0);      measure(1024, 1'b0, "R3 positive");
        apply(-1024, 1'b0);     measure(-1024, 1'b0, "R4 negative");
        apply(300, 1'b0);       measure(300, 1'b0, "R3 small positive");
        apply(2047, 1'b0);      measure(2047, 1'b0, "R5 clamp top slow");
        apply(-2048, 1'b0);     measure(-2048, 1'b0, "R5 clamp bottom slow");
        apply(512, 1'b1);       measure(512, 1'b1, "R6 fast period");
        apply(2047, 1'b1);      measure(2047, 1'b1, "R5 R6 clamp top fast");
        apply(0, 1'b1);         measure(0, 1'b1, "R2 R6 zero fast");

        // R7: mid-period change must not touch the running period
        apply(0, 1'b0);
        do @(negedge clk); while (m_cnt != PER_SLOW / 2);
        sample = SAMPLE_W'(2047);
        do begin
            @(negedge clk);
            check_bit(leg_p_o, leg_n_o, "R7 mid-period change leaked");
        end while (m_cnt != 0);

        // R8: request at an arbitrary point
        repeat (37) @(negedge clk);
        hiz = 1'b1;
        repeat (20) begin
            @(negedge clk);
            check_bit(en_p_o | en_n_o | leg_p_o | leg_n_o, 1'b0, "R8 outputs during request");
        end
        // R9: restart timing
        hiz = 1'b0;
        @(negedge clk); check_bit(en_p_o, 1'b0, "R9 en after first edge");
        @(negedge clk); check_bit(en_p_o, 1'b0, "R9 en after second edge");
        @(negedge clk);
        check_bit(en_p_o & en_n_o, 1'b1, "R9 enables on third edge");
        check_bit(leg_p_o & leg_n_o, 1'b1, "R9 legs start together");

        // request coinciding with a period wrap and a new sample
        repeat (10) @(negedge clk);
        do @(negedge clk); while (!(m_st == 2 && m_cnt == m_per - 1));
        hiz = 1'b1;
        sample = SAMPLE_W'(-700);
        fsel = 1'b1;
        @(negedge clk);
        check_bit(en_p_o | en_n_o | leg_p_o | leg_n_o, 1'b0, "R8 request on wrap edge");
        repeat (5) @(negedge clk);
        hiz = 1'b0;
        repeat (2 * PER_SLOW) @(negedge clk);
        measure(-700, 1'b1, "R4 R6 after wrap restart");

        cmp_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule